// File: doc/BRIEF.md
# Multi-Mode Self-Test Register

This block is a small register that sits between two clouds of combinational logic and can take on four roles, picked by a two-bit mode input sampled at each rising clock edge. As a plain parallel register it passes the upstream logic's outputs on to the downstream logic. As a serial shift register it lets a tester load a state and read it back through a scan chain. As a synchronous clear it zeroes the whole register. In self-test mode it becomes a linear feedback shift register that XORs its parallel inputs into the shifted state.

In self-test mode, holding the parallel inputs at zero makes the register a pseudo-random pattern source. With the default three bits it steps through all seven nonzero states. Feeding it the responses of the logic under test instead folds that stream into a signature. The width and the feedback taps are parameters. The defaults are three bits with feedback taken from the two upper bits, which gives the primitive polynomial x^3 + x^2 + 1. The serial output always shows the top bit of the register.

Top module: `bilbo_reg`

## Requirements
- R1: While rst_n is low at a rising clock edge, q becomes 000 after that edge, whatever the mode, d and si are.
- R2: With mode = 2'b11 (parallel), q takes the value of d at the clock edge.
- R3: With mode = 2'b00 (shift), the edge loads q[0] from si, q[1] from the old q[0] and q[2] from the old q[1]. d is ignored.
- R4: With mode = 2'b10 (clear), q becomes 000 at the clock edge, and d and si have no effect.
- R5: With mode = 2'b01 (self-test), the next state is q[2] = q[1]^d[2], q[1] = q[0]^d[1] and q[0] = q[1]^q[2]^d[0], all taken from the values before the edge.
- R6: In self-test mode with d = 000, starting from 001 the register steps through 010, 101, 011, 111, 110, 100 and is back at 001 on the seventh edge.
- R7: In self-test mode with d = 000, a nonzero state never steps to 000.
- R8: so equals q[2] in every mode and at all times.
- R9: Cleared to 000 and then clocked in self-test mode with the d stream 011, 101, 110, 001, the register holds the signature 110. The same stream after another clear gives the same signature.
- R10: A change of mode takes effect at the first clock edge at which the new value is present. The edge before it still uses the old mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Mode select: 00 shift, 01 self-test, 10 clear, 11 parallel |
| d | input | 3 | Parallel data or response input |
| si | input | 1 | Serial input into bit 0 |
| q | output | 3 | Register state, parallel output |
| so | output | 1 | Serial output, always q[2] |

## Verification
The generator is seeded with 001 through a parallel load and run with zero inputs for a full period of seven edges. This checks the tap positions and the maximal length of the sequence together. A wrong tap shows up as a short cycle or a skipped state. Shift mode is run with an arbitrary bit pattern shifted in and a loaded word shifted out, which separates the shift order from a parallel load. A fixed response stream compacted twice, each time after a clear, shows that the XOR of d into each bit position is right and that the result repeats. The vector order also switches mode on consecutive edges, so an off-by-one delay on the mode would be caught.

// File: rtl/bilbo_pkg.sv
// Shared definitions for the multi-mode self-test register.
// Assumes the mode encoding is fixed by the surrounding test controller.
package bilbo_pkg;

    typedef enum logic [1:0] {
        MODE_SHIFT = 2'b00,
        MODE_SELF  = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_PAR   = 2'b11
    } bilbo_mode_e;

endpackage

// File: rtl/bilbo_fbk.sv
// Feedback generator: XOR of the state bits selected by TAP_MASK.
// Assumes TAP_MASK describes a primitive polynomial for a maximal sequence.
module bilbo_fbk #(
    parameter int              WIDTH    = 3,
    parameter logic [WIDTH-1:0] TAP_MASK = 3'b110
) (
    input  logic [WIDTH-1:0] state_i,
    output logic             fbk_o
);

    logic [WIDTH-1:0] tapped;

    // Select the tapped bits one by one.
    for (genvar t = 0; t < WIDTH; t++) begin : g_tap
        if (TAP_MASK[t]) begin : g_on
            assign tapped[t] = state_i[t];
        end else begin : g_off
            assign tapped[t] = 1'b0;
        end
    end

    assign fbk_o = ^tapped;

endmodule

// File: rtl/bilbo_next.sv
// Next-state selector: picks the parallel, shift, clear or self-test value
// for each bit. Assumes the feedback bit is supplied by bilbo_fbk.
module bilbo_next
    import bilbo_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  bilbo_mode_e      mode_i,
    input  logic [WIDTH-1:0] state_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    input  logic             fbk_i,
    output logic [WIDTH-1:0] next_o
);

    logic [WIDTH-1:0] shift_src;
    logic [WIDTH-1:0] lfsr_src;

    // Per-bit sources: bit 0 takes the serial input or feedback, others shift.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (b == 0) begin : g_head
            assign shift_src[b] = ser_i;
            assign lfsr_src[b]  = fbk_i;
        end else begin : g_body
            assign shift_src[b] = state_i[b-1];
            assign lfsr_src[b]  = state_i[b-1];
        end
    end

    // Choose the next state from the mode.
    always_comb begin
        unique case (mode_i)
            MODE_SHIFT: next_o = shift_src;
            MODE_SELF:  next_o = lfsr_src ^ par_i;
            MODE_CLEAR: next_o = '0;
            default:    next_o = par_i;
        endcase
    end

endmodule

// File: rtl/bilbo_reg.sv
// Multi-mode self-test register (top). Holds WIDTH flops, which work as a
// parallel register, a scan shift register, a synchronous clear or an
// LFSR that generates patterns or compacts signatures.
// Assumes a single clock and a synchronous active-low reset.
module bilbo_reg
    import bilbo_pkg::*;
#(
    parameter int               WIDTH    = 3,
    parameter logic [WIDTH-1:0] TAP_MASK = 3'b110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] d,
    input  logic             si,
    output logic [WIDTH-1:0] q,
    output logic             so
);

    localparam int MSB = WIDTH - 1;

    bilbo_mode_e      mode_e;
    logic             fbk;
    logic [WIDTH-1:0] q_next;

    assign mode_e = bilbo_mode_e'(mode);

    bilbo_fbk #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) i_fbk (
        .state_i (q),
        .fbk_o   (fbk)
    );

    bilbo_next #(.WIDTH(WIDTH)) i_next (
        .mode_i  (mode_e),
        .state_i (q),
        .par_i   (d),
        .ser_i   (si),
        .fbk_i   (fbk),
        .next_o  (q_next)
    );

    // State flops with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    // Serial output is the last stage.
    assign so = q[MSB];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> q == '0);

    // R2
    par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b11 |=> q == $past(d));

    // R3
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b00 |=> q == {$past(q[MSB-1:0]), $past(si)});

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b10 |=> q == '0);

    // R5
    self_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b01 |=> q[MSB:1] == ($past(q[MSB-1:0]) ^ $past(d[MSB:1])));

    // R7
    no_lockup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && d == '0 && q != '0) |=> q != '0);

endmodule

// File: tb/test_bilbo_reg.sv
`timescale 1ns/1ps
module test_bilbo_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b10;
    logic [2:0] d = 3'b000;
    logic       si = 1'b0;
    logic [2:0] q;
    logic       so;

    int vecs = 0;
    int errs = 0;

    always #2.5 clk = ~clk;

    bilbo_reg i_bilbo_reg (
        .clk(clk), .rst_n(rst_n), .mode(mode), .d(d), .si(si), .q(q), .so(so)
    );

    // Vector: {mode[1:0], d[2:0], si, expected q[2:0]}
    localparam int NV = 25;
    localparam logic [8:0] VEC [NV] = '{
        9'b11_001_0_001,                       // R2 seed 001
        9'b01_000_0_010, 9'b01_000_0_101,      // R6 period walk
        9'b01_000_0_011, 9'b01_000_0_111,
        9'b01_000_0_110, 9'b01_000_0_100,
        9'b01_000_0_001,                       // R6 back at seed after 7
        9'b10_101_1_000,                       // R4 clear ignores d, si
        9'b00_111_1_001, 9'b00_000_0_010,      // R3 shift in 1,0,1
        9'b00_010_1_101,
        9'b11_110_0_110,                       // R10 mode switch at next edge
        9'b00_000_0_100, 9'b00_000_0_000,      // R3 shift out
        9'b10_000_0_000,                       // R9 clear before compaction
        9'b01_011_0_011, 9'b01_101_0_010,
        9'b01_110_0_011, 9'b01_001_0_110,      // R9 signature 110
        9'b10_111_1_000,                       // R4 clear again
        9'b01_011_0_011, 9'b01_101_0_010,
        9'b01_110_0_011, 9'b01_001_0_110       // R9 repeatable
    };

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'b00:   return "R3 shift";
            2'b01:   return "R5 self-test";
            2'b10:   return "R4 clear";
            default: return "R2 parallel";
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive on the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic [1:0] m, input logic [2:0] dv, input logic s);
        @(negedge clk);
        mode = m; d = dv; si = s;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset q", q, 3'b000);
        check("R8 reset so", {2'b00, so}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][8:7], VEC[i][6:4], VEC[i][3]);
            check(tag_of(VEC[i][8:7]), q, VEC[i][2:0]);
            check("R8 so", {2'b00, so}, {2'b00, VEC[i][2]});
        end

        // R1 reset wins over parallel load
        step(2'b11, 3'b111, 1'b1);
        check("R2 load 111", q, 3'b111);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset over parallel", q, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 and R8: shift out a loaded word
        step(2'b11, 3'b101, 1'b0);
        check("R8 so before shift 1", {2'b00, so}, 3'b001);
        step(2'b00, 3'b000, 1'b0);
        check("R8 so before shift 2", {2'b00, so}, 3'b000);
        step(2'b00, 3'b000, 1'b0);
        check("R8 so before shift 3", {2'b00, so}, 3'b001);
        check("R3 shifted state", q, 3'b100);

        // R7: long run from seed 111 never hits zero
        step(2'b11, 3'b111, 1'b0);
        for (int k = 0; k < 21; k++) begin
            step(2'b01, 3'b000, 1'b0);
            if (q == 3'b000) check("R7 nonzero", q, 3'b001);
        end
        vecs++;
        check("R7 period return to 111", q, 3'b111);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule